// File: doc/BRIEF.md
# Parity UART Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. A frame is a low start bit, then the data bits with the least-significant bit first, then an optional parity bit, and finally one high stop bit. The parity bit is present or absent by build parameter, and its sense (even or odd) is also a build parameter.

A client raises `tx_en` for a cycle together with the word on `tx_data`. The word is captured in that cycle, so the client may change `tx_data` right afterwards. Bit timing comes from an internal divider. The divider turns the system clock into a one-cycle baud tick every `BAUD_DIV` cycles, and the line moves only on those ticks. `tx_busy` covers the whole frame. A request made while the stop bit is on the line chains the next frame straight after it, with no idle bit time between the two frames.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `tx_line` is 1 and `tx_busy` is 0.
- R2: A frame has DATA_W + PARITY_ON + 2 bit periods. Bit period 0 is 0 (start), periods 1..DATA_W carry `tx_data[0]`..`tx_data[DATA_W-1]`, the next period carries the parity bit when PARITY_ON = 1, and the last period is 1 (stop).
- R3: With PARITY_KIND even (the default), the parity bit is the XOR of all data bits. With odd, it is the inverse of that XOR.
- R4: Each bit period lasts exactly BAUD_DIV clock cycles. `tx_line` changes only on the clock edge of a baud tick.
- R5: A request is accepted when `tx_en` is 1 and no frame is waiting or running. The word sent is the `tx_data` value of the accepting cycle, and later changes of `tx_data` do not alter it.
- R6: `tx_en` pulses during the start, data or parity bits of a running frame are ignored. No extra frame follows, and the running frame is unchanged.
- R7: A `tx_en` pulse during the stop bit queues a new frame. Its start bit begins on the same tick that ends the stop bit, and `tx_busy` stays 1 across the boundary.
- R8: `tx_busy` rises on the same edge that drives the start bit. It stays 1 through the stop bit and falls on the tick that ends the stop bit when no frame is chained.
- R9: While `tx_busy` is 0, `tx_line` is 1.
- R10: Asserting `rst` in the middle of a frame aborts it. After the next edge the line is 1 and busy is 0, and no frame resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Send request strobe |
| tx_data | input | DATA_W | Word to send, sampled with the accepted request |
| tx_busy | output | 1 | High from the start bit until the end of the last stop bit |
| tx_line | output | 1 | Registered serial output, idles high |

## Verification
Most faults in the shift register or the bit-position counter show at the port within one bit period. A wrong preload or shift shows up as a wrong data or parity bit in the received word. An off-by-one in the position counter makes the frame a bit time too long or too short, which moves the fall of `tx_busy` or the next start bit by BAUD_DIV cycles. A fault in the request latch shows up only on a later frame. Either a spurious frame appears after a request made mid-frame, or a chained frame is lost and the line stays high where a start bit belongs. To catch both cases, the line is sampled in every cycle of every bit period, and for several bit times after each frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_kind_e;

   function automatic int frame_bits(input int dw, input bit par_on);
      return dw + (par_on ? 1 : 0) + 2;
   endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
   parameter int BAUD_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int CW = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;
   localparam logic [CW-1:0] TOP = CW'(BAUD_DIV - 1);

   if (BAUD_DIV < 2) begin : g_bad_div
      $error("uart_baud_gen: BAUD_DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick_o = (cnt_q == TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R4: the tick is a one-cycle pulse
   a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);

endmodule

// File: rtl/uart_frame_build.sv
module uart_frame_build #(
   parameter int                    DATA_W      = 8,
   parameter bit                    PARITY_ON   = 1'b1,
   parameter uart_tx_pkg::par_kind_e PARITY_KIND = uart_tx_pkg::PAR_EVEN,
   localparam int                   FRAME_W     = uart_tx_pkg::frame_bits(DATA_W, PARITY_ON)
) (
   input  logic [DATA_W-1:0]  data_i,
   output logic [FRAME_W-1:0] frame_o
);
   if (PARITY_ON) begin : g_par
      logic par_bit;
      assign par_bit = (^data_i) ^ (PARITY_KIND == uart_tx_pkg::PAR_ODD);
      assign frame_o = {1'b1, par_bit, data_i, 1'b0};
   end else begin : g_nopar
      assign frame_o = {1'b1, data_i, 1'b0};
   end

   // R2: start and stop positions of the assembled frame
   always_comb begin
      a_r2_frame_ends: assert (frame_o[0] == 1'b0 && frame_o[FRAME_W-1] == 1'b1);
   end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = 11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick_i,
   input  logic               en_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic [DATA_W-1:0]  load_data_o,
   output logic               line_o,
   output logic               busy_o
);
   localparam int PW = $clog2(FRAME_W + 1);
   localparam logic [PW-1:0] LAST = PW'(FRAME_W);

   logic [FRAME_W-1:0] shreg_q;
   logic [PW-1:0]      pos_q;
   logic               active_q;
   logic               req_q;
   logic [DATA_W-1:0]  data_q;
   logic               line_q;

   logic in_stop;
   logic accept;
   logic req_n;
   logic start;

   assign in_stop     = active_q && (pos_q == LAST);
   assign accept      = en_i && !req_q && (!active_q || in_stop);
   assign req_n       = req_q || accept;
   assign load_data_o = accept ? data_i : data_q;
   assign start       = tick_i && req_n && (!active_q || in_stop);

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q  <= '1;
         pos_q    <= '0;
         active_q <= 1'b0;
         req_q    <= 1'b0;
         data_q   <= '0;
         line_q   <= 1'b1;
      end else begin
         data_q <= load_data_o;
         req_q  <= start ? 1'b0 : req_n;
         if (start) begin
            line_q   <= frame_i[0];
            shreg_q  <= {1'b0, frame_i[FRAME_W-1:1]};
            pos_q    <= PW'(1);
            active_q <= 1'b1;
         end else if (tick_i && in_stop) begin
            line_q   <= 1'b1;
            shreg_q  <= '0;
            pos_q    <= '0;
            active_q <= 1'b0;
         end else if (tick_i && active_q) begin
            line_q  <= shreg_q[0];
            shreg_q <= {1'b0, shreg_q[FRAME_W-1:1]};
            pos_q   <= pos_q + PW'(1);
         end
      end
   end

   assign line_o = line_q;
   assign busy_o = active_q;

   // R4: the line holds between baud ticks
   a_r4_line_holds: assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(line_o));
   // R8: busy rises together with the start bit
   a_r8_busy_with_start: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> !line_o);
   // R9: idle line is high
   a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> line_o);
   // R5: captured word is frozen until the stop bit
   a_r5_word_frozen: assert property (@(posedge clk) disable iff (rst)
      (active_q && pos_q != LAST) |=> $stable(data_q));
   // R7: a queued request chains straight into a start bit
   a_r7_chain: assert property (@(posedge clk) disable iff (rst)
      (tick_i && in_stop && req_q) |=> (busy_o && !line_o));
   // R2: bit position stays inside the frame
   a_r2_pos_range: assert property (@(posedge clk) disable iff (rst)
      pos_q <= LAST);
   // R10: reset forces an idle line
   a_r10_reset_idle: assert property (@(posedge clk)
      rst |=> (line_o && !busy_o));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int                    DATA_W      = 8,
   parameter bit                    PARITY_ON   = 1'b1,
   parameter uart_tx_pkg::par_kind_e PARITY_KIND = uart_tx_pkg::PAR_EVEN,
   parameter int                    BAUD_DIV    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              tx_line
);
   localparam int FRAME_W = uart_tx_pkg::frame_bits(DATA_W, PARITY_ON);

   if (DATA_W < 1) begin : g_bad_width
      $error("uart_frame_tx: DATA_W must be at least 1");
   end

   logic               tick;
   logic [DATA_W-1:0]  load_data;
   logic [FRAME_W-1:0] frame;

   uart_baud_gen #(
      .BAUD_DIV (BAUD_DIV)
   ) u_baud (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   uart_frame_build #(
      .DATA_W      (DATA_W),
      .PARITY_ON   (PARITY_ON),
      .PARITY_KIND (PARITY_KIND)
   ) u_build (
      .data_i  (load_data),
      .frame_o (frame)
   );

   uart_tx_shifter #(
      .DATA_W  (DATA_W),
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick),
      .en_i        (tx_en),
      .data_i      (tx_data),
      .frame_i     (frame),
      .load_data_o (load_data),
      .line_o      (tx_line),
      .busy_o      (tx_busy)
   );

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;
   localparam int D = 4;
   localparam int W = 8;
   localparam int F = W + 1 + 2;

   // {expected even parity, data}
   localparam logic [8:0] VEC [0:6] = '{
      {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b0, 8'hA5}, {1'b1, 8'h01},
      {1'b1, 8'h80}, {1'b1, 8'h7F}, {1'b0, 8'h3C}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tx_en = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic tx_busy;
   logic tx_line;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   uart_frame_tx #(.DATA_W(W), .BAUD_DIV(D)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .tx_en   (tx_en),
      .tx_data (tx_data),
      .tx_busy (tx_busy),
      .tx_line (tx_line)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic request(input logic [W-1:0] d);
      tx_en   = 1'b1;
      tx_data = d;
      @(negedge clk);
      tx_en   = 1'b0;
      tx_data = ~d;
   endtask

   task automatic wait_start();
      bit seen = 1'b0;
      bit early = 1'b0;
      for (int n = 0; n < 4 * D + 2; n++) begin
         if (tx_line === 1'b0) begin
            seen = 1'b1;
            break;
         end
         if (tx_busy !== 1'b0) early = 1'b1;
         @(negedge clk);
      end
      chk(seen, "R5 start bit after request", int'(seen), 1);
      chk(!early, "R8 busy low before start", int'(early), 0);
      chk(tx_busy === 1'b1, "R8 busy with start bit", int'(tx_busy), 1);
   endtask

   task automatic rx_frame(input int inj_bit, input logic [W-1:0] inj, output logic [F-1:0] bits);
      int mism = 0;
      int bz = 0;
      for (int i = 0; i < F; i++) begin
         for (int j = 0; j < D; j++) begin
            if (j == 0) bits[i] = tx_line;
            else if (tx_line !== bits[i]) mism++;
            if (tx_busy !== 1'b1) bz++;
            if (i == inj_bit && j == 1) begin
               tx_en = 1'b1;
               tx_data = inj;
            end
            if (i == inj_bit && j == 2) begin
               tx_en = 1'b0;
               tx_data = ~inj;
            end
            @(negedge clk);
         end
      end
      chk(mism == 0, "R4 bit held for BAUD_DIV cycles", mism, 0);
      chk(bz == 0, "R8 busy through frame", bz, 0);
   endtask

   task automatic check_frame(input logic [F-1:0] bits, input logic [W-1:0] d, input logic p);
      chk(bits[0] == 1'b0, "R2 start bit", int'(bits[0]), 0);
      chk(bits[W:1] == d, "R2 R5 data bits", int'(bits[W:1]), int'(d));
      chk(bits[W+1] == p, "R3 parity bit", int'(bits[W+1]), int'(p));
      chk(bits[F-1] == 1'b1, "R2 stop bit", int'(bits[F-1]), 1);
   endtask

   task automatic check_idle(input int n, input string rq);
      int bad = 0;
      for (int k = 0; k < n; k++) begin
         if (tx_line !== 1'b1 || tx_busy !== 1'b0) bad++;
         @(negedge clk);
      end
      chk(bad == 0, rq, bad, 0);
   endtask

   initial begin
      logic [F-1:0] bits;
      repeat (3) @(negedge clk);
      chk(tx_line === 1'b1 && tx_busy === 1'b0, "R1 reset state", int'({tx_line, tx_busy}), 2);
      rst = 1'b0;
      @(negedge clk);
      chk(tx_line === 1'b1 && tx_busy === 1'b0, "R1 after release", int'({tx_line, tx_busy}), 2);

      // table walk: one frame per vector
      for (int v = 0; v < 7; v++) begin
         request(VEC[v][7:0]);
         wait_start();
         rx_frame(-1, '0, bits);
         check_frame(bits, VEC[v][7:0], VEC[v][8]);
         chk(tx_busy === 1'b0, "R8 busy falls after stop", int'(tx_busy), 0);
         check_idle(2 * D, "R9 idle line high");
      end

      // R6: request during a data bit is ignored
      request(8'h96);
      wait_start();
      rx_frame(3, 8'h11, bits);
      check_frame(bits, 8'h96, 1'b0);
      check_idle(3 * D, "R6 no frame from mid-frame request");

      // R7: request during the stop bit chains the next frame
      request(8'h5A);
      wait_start();
      rx_frame(F - 1, 8'hC3, bits);
      check_frame(bits, 8'h5A, 1'b0);
      chk(tx_line === 1'b0 && tx_busy === 1'b1, "R7 chained start without gap",
          int'({tx_line, tx_busy}), 1);
      rx_frame(-1, '0, bits);
      check_frame(bits, 8'hC3, 1'b0);
      chk(tx_busy === 1'b0, "R7 busy falls after chained frame", int'(tx_busy), 0);
      check_idle(2 * D, "R9 idle after chain");

      // R10: reset in the middle of a frame
      request(8'h0F);
      wait_start();
      repeat (3 * D) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(tx_line === 1'b1 && tx_busy === 1'b0, "R10 abort on reset", int'({tx_line, tx_busy}), 2);
      rst = 1'b0;
      @(negedge clk);
      check_idle(F * D, "R10 no resume after reset");

      request(8'hE7);
      wait_start();
      rx_frame(-1, '0, bits);
      check_frame(bits, 8'hE7, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #750000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule